// File: doc/BRIEF.md
# Radio Slot Power and Enable Sequencer

This block sits on the host side of a low-IF radio and drives its control lines through one receive or transmit slot at a time. It raises the supply-regulator and transceiver power lines and waits for the supplies to settle. It then opens a programming window on the serial bus enable, which an external shift port fills with bits, and counts the synthesizer settling time from the moment that window closes. Only after that does it raise the receive or transmit enable. Every wait is a count of system clock cycles set by a parameter.

In a transmit slot the block also produces the serial bit stream for the radio's data input. It starts with an alternating one-zero preamble of configurable length at a configurable number of clocks per bit, and then passes the host's payload bit through. The open-loop enable, which is active low, is low for exactly the cycles in which the transmit enable is high. When a slot ends, the block goes back to power-down or stays powered and idle, as the host asks. A slot request that arrives while the block is busy is stored together with its direction and is served as soon as the current slot ends.

Top module: `radio_slot_seq`

## Requirements
- R1: Out of reset the regulator power, transceiver power, receive enable, transmit enable, transmit bit and busy outputs are all 0. The bus enable `busEnN` (active low) and the open-loop enable `openLoopN` (active low) are both 1.
- R2: When a slot request (`slotIsTx`: 1 = transmit, 0 = receive) arrives in power-down, both power lines and `busy` rise in the next cycle, and `busEnN` falls exactly PWR_CYC cycles after the power lines rise.
- R3: `busEnN` stays low until `shiftDone` is sampled high, and is high again in the next cycle.
- R4: A receive slot, and a transmit slot that does not come straight from power-down, raises its slot enable exactly PLL_CYC cycles after `busEnN` rises.
- R5: A transmit slot entered straight from power-down raises `txOn` exactly COLD_TX_CYC cycles after `busEnN` rises.
- R6: In a receive slot `rxOn` stays high and `txOn` stays low until `endSlot` is sampled high.
- R7: `openLoopN` is low in exactly the cycles in which `txOn` is high.
- R8: In a transmit slot, bit k (k = 0 .. PRE_BITS-1) lasts BIT_CYC cycles and equals 1 when k is even and 0 when k is odd, with bit 0 starting in the first `txOn` cycle. From cycle PRE_BITS*BIT_CYC of the slot onward, `txBitOut` equals `txBitIn` and `txPayloadEn` is 1. Before that cycle `txPayloadEn` is 0.
- R9: `rxOn` and `txOn` are never high together, and `txBitOut` is 0 whenever `txOn` is low.
- R10: With nothing pending, `endSlot` together with `sleepReq`=1 returns every line to its R1 value in the next cycle. With `sleepReq`=0, the block stays powered and idle, and a later request pulls `busEnN` low in the very next cycle, with no power-up wait.
- R11: A request that arrives during a wait or a slot is held with its direction. When `endSlot` comes, programming for the held request starts in the next cycle, ahead of `sleepReq`, and the slot that follows has the held direction.
- R12: `busy` is 1 during the power-up wait, the programming window and the settling wait, and 0 during slots, idle and power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slotReq | input | 1 | One-cycle request for a new slot |
| slotIsTx | input | 1 | Direction of the request: 1 transmit, 0 receive |
| sleepReq | input | 1 | At slot end, return to power-down when 1 |
| endSlot | input | 1 | Ends the active slot |
| shiftDone | input | 1 | External shift port has sent the programming word |
| txBitIn | input | 1 | Host payload bit |
| regPwrUp | output | 1 | Supply regulator power-up line |
| trxPwrUp | output | 1 | Transceiver power-up line |
| busEnN | output | 1 | Serial bus enable, low during programming |
| rxOn | output | 1 | Receive enable |
| txOn | output | 1 | Transmit enable, starts the PA ramp |
| openLoopN | output | 1 | Open-loop enable, active low |
| txBitOut | output | 1 | Bit stream to the radio's data input |
| txPayloadEn | output | 1 | Preamble finished, payload is passing through |
| busy | output | 1 | A wait or the programming window is in progress |

## Verification
The bench counts the exact cycles from the power lines rising to the bus enable falling, and from the bus enable rising to each slot enable. It does this for a cold receive slot, a cold transmit slot and several warm turnarounds. A timer that is off by one, or a cold transmit that uses the ordinary settling count, shows up as a wrong count. Every transmit cycle is compared with the arithmetic preamble and payload pattern, which catches a preamble that starts with 0, has the wrong length or has the wrong bit width. A request injected in the middle of a settling wait must leave that wait's length unchanged, must win over a sleep request at slot end, and must keep its receive direction. A design that drops the request, or that lets sleep win, goes dark or opens the wrong slot.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_PWRUP,
    ST_PROG,
    ST_SETTLE,
    ST_IDLE,
    ST_RX,
    ST_TX
  } seqState_t;

  typedef enum logic [1:0] {
    WAIT_PWR,
    WAIT_PLL,
    WAIT_COLD
  } waitSel_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic     loadTimer;
    waitSel_t waitSel;
    logic     startPre;
    logic     txActive;
  } dpCtrl_t;

endpackage

// File: rtl/slot_seq_dp.sv
module slot_seq_dp
  import slot_seq_pkg::*;
#(
  parameter int PWR_CYC     = 4000,
  parameter int PLL_CYC     = 20000,
  parameter int COLD_TX_CYC = 25000,
  parameter int PRE_BITS    = 16,
  parameter int BIT_CYC     = 87
) (
  input  logic    clk,
  input  logic    rst_n,
  input  dpCtrl_t ctl,
  input  logic    txBitIn,
  output logic    timerZero,
  output logic    txBitOut,
  output logic    txPayloadEn
);

  localparam int MAX_A    = (PWR_CYC > PLL_CYC) ? PWR_CYC : PLL_CYC;
  localparam int MAX_WAIT = (MAX_A > COLD_TX_CYC) ? MAX_A : COLD_TX_CYC;
  localparam int TW       = $clog2(MAX_WAIT + 1);
  localparam int BW       = $clog2(BIT_CYC + 1);
  localparam logic [TW-1:0] PWR_LD  = TW'(PWR_CYC - 1);
  localparam logic [TW-1:0] PLL_LD  = TW'(PLL_CYC - 1);
  localparam logic [TW-1:0] COLD_LD = TW'(COLD_TX_CYC - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(BIT_CYC - 1);

  // wait timer: a load of N-1 gives a wait of N cycles
  logic [TW-1:0] waitCnt;
  logic [TW-1:0] loadVal;

  always_comb begin
    case (ctl.waitSel)
      WAIT_PWR:  loadVal = PWR_LD;
      WAIT_COLD: loadVal = COLD_LD;
      default:   loadVal = PLL_LD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                waitCnt <= '0;
    else if (ctl.loadTimer)    waitCnt <= loadVal;
    else if (waitCnt != '0)    waitCnt <= waitCnt - 1'b1;
  end

  assign timerZero = (waitCnt == '0);

  // preamble generator
  logic inPre;
  logic preBit;

  generate
    if (PRE_BITS == 0) begin : g_noPre
      assign inPre  = 1'b0;
      assign preBit = 1'b0;
    end else begin : g_pre
      localparam int PW = $clog2(PRE_BITS + 2);
      localparam logic [PW-1:0] PRE_END = PW'(PRE_BITS);
      logic [PW-1:0] preCnt;
      logic [BW-1:0] bitCyc;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          preCnt <= '0;
          bitCyc <= '0;
        end else if (ctl.startPre) begin
          preCnt <= '0;
          bitCyc <= '0;
        end else if (ctl.txActive) begin
          if (bitCyc == BIT_LAST) begin
            bitCyc <= '0;
            if (preCnt != PRE_END) preCnt <= preCnt + 1'b1;
          end else begin
            bitCyc <= bitCyc + 1'b1;
          end
        end
      end

      assign inPre  = (preCnt != PRE_END);
      assign preBit = ~preCnt[0];
    end
  endgenerate

  assign txBitOut    = ctl.txActive & (inPre ? preBit : txBitIn);
  assign txPayloadEn = ctl.txActive & ~inPre;

endmodule

// File: rtl/slot_seq_ctrl.sv
module slot_seq_ctrl
  import slot_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    slotReq,
  input  logic    slotIsTx,
  input  logic    sleepReq,
  input  logic    endSlot,
  input  logic    shiftDone,
  input  logic    timerZero,
  output dpCtrl_t ctl,
  output logic    regPwrUp,
  output logic    trxPwrUp,
  output logic    busEnN,
  output logic    rxOn,
  output logic    txOn,
  output logic    openLoopN,
  output logic    busy
);

  seqState_t state, nextState;
  logic curTx, nextTx;
  logic coldStart, nextCold;
  logic pendValid, pendTx;
  logic takeReq;
  logic reqAvail, reqTx;

  assign reqAvail = slotReq | pendValid;
  assign reqTx    = slotReq ? slotIsTx : pendTx;

  always_comb begin
    nextState     = state;
    nextTx        = curTx;
    nextCold      = coldStart;
    takeReq       = 1'b0;
    ctl.loadTimer = 1'b0;
    ctl.waitSel   = WAIT_PLL;
    ctl.startPre  = 1'b0;
    ctl.txActive  = (state == ST_TX);
    case (state)
      ST_OFF: begin
        if (reqAvail) begin
          nextState     = ST_PWRUP;
          nextTx        = reqTx;
          nextCold      = 1'b1;
          takeReq       = 1'b1;
          ctl.loadTimer = 1'b1;
          ctl.waitSel   = WAIT_PWR;
        end
      end
      ST_PWRUP: begin
        if (timerZero) nextState = ST_PROG;
      end
      ST_PROG: begin
        if (shiftDone) begin
          nextState     = ST_SETTLE;
          ctl.loadTimer = 1'b1;
          ctl.waitSel   = (curTx && coldStart) ? WAIT_COLD : WAIT_PLL;
        end
      end
      ST_SETTLE: begin
        if (timerZero) begin
          nextState    = curTx ? ST_TX : ST_RX;
          ctl.startPre = curTx;
          nextCold     = 1'b0;
        end
      end
      ST_IDLE: begin
        if (reqAvail) begin
          nextState = ST_PROG;
          nextTx    = reqTx;
          takeReq   = 1'b1;
        end
      end
      ST_RX, ST_TX: begin
        if (endSlot) begin
          if (reqAvail) begin
            nextState = ST_PROG;
            nextTx    = reqTx;
            takeReq   = 1'b1;
          end else if (sleepReq) begin
            nextState = ST_OFF;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      default: nextState = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OFF;
      curTx     <= 1'b0;
      coldStart <= 1'b0;
      pendValid <= 1'b0;
      pendTx    <= 1'b0;
    end else begin
      state     <= nextState;
      curTx     <= nextTx;
      coldStart <= nextCold;
      if (takeReq) begin
        pendValid <= 1'b0;
      end else if (slotReq) begin
        pendValid <= 1'b1;
        pendTx    <= slotIsTx;
      end
    end
  end

  assign regPwrUp  = (state != ST_OFF);
  assign trxPwrUp  = (state != ST_OFF);
  assign busEnN    = (state != ST_PROG);
  assign rxOn      = (state == ST_RX);
  assign txOn      = (state == ST_TX);
  assign openLoopN = (state != ST_TX);
  assign busy      = (state == ST_PWRUP) || (state == ST_PROG) || (state == ST_SETTLE);

endmodule

// File: rtl/radio_slot_seq.sv
module radio_slot_seq
  import slot_seq_pkg::*;
#(
  parameter int PWR_CYC     = 4000,
  parameter int PLL_CYC     = 20000,
  parameter int COLD_TX_CYC = 25000,
  parameter int PRE_BITS    = 16,
  parameter int BIT_CYC     = 87
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slotReq,
  input  logic slotIsTx,
  input  logic sleepReq,
  input  logic endSlot,
  input  logic shiftDone,
  input  logic txBitIn,
  output logic regPwrUp,
  output logic trxPwrUp,
  output logic busEnN,
  output logic rxOn,
  output logic txOn,
  output logic openLoopN,
  output logic txBitOut,
  output logic txPayloadEn,
  output logic busy
);

  dpCtrl_t ctl;
  logic    timerZero;

  slot_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .slotReq   (slotReq),
    .slotIsTx  (slotIsTx),
    .sleepReq  (sleepReq),
    .endSlot   (endSlot),
    .shiftDone (shiftDone),
    .timerZero (timerZero),
    .ctl       (ctl),
    .regPwrUp  (regPwrUp),
    .trxPwrUp  (trxPwrUp),
    .busEnN    (busEnN),
    .rxOn      (rxOn),
    .txOn      (txOn),
    .openLoopN (openLoopN),
    .busy      (busy)
  );

  slot_seq_dp #(
    .PWR_CYC     (PWR_CYC),
    .PLL_CYC     (PLL_CYC),
    .COLD_TX_CYC (COLD_TX_CYC),
    .PRE_BITS    (PRE_BITS),
    .BIT_CYC     (BIT_CYC)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .txBitIn     (txBitIn),
    .timerZero   (timerZero),
    .txBitOut    (txBitOut),
    .txPayloadEn (txPayloadEn)
  );

endmodule

// File: rtl/slot_seq_chk.sv
module slot_seq_chk #(
  parameter int PLL_CYC     = 20000,
  parameter int COLD_TX_CYC = 25000
) (
  input logic clk,
  input logic rst_n,
  input logic shiftDone,
  input logic endSlot,
  input logic regPwrUp,
  input logic trxPwrUp,
  input logic busEnN,
  input logic rxOn,
  input logic txOn,
  input logic openLoopN,
  input logic txBitOut,
  input logic busy
);

  localparam int SW = $clog2(PLL_CYC + COLD_TX_CYC + 2);
  localparam logic [SW-1:0] SAT = '1;
  localparam logic [SW-1:0] PLL_W = SW'(PLL_CYC);

  // cycles since the bus enable last returned high
  logic [SW-1:0] sinceEn;
  logic          prevEn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sinceEn <= '0;
      prevEn  <= 1'b1;
    end else begin
      prevEn <= busEnN;
      if (busEnN && !prevEn)   sinceEn <= SW'(1);
      else if (sinceEn != SAT) sinceEn <= sinceEn + 1'b1;
    end
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n) !(rxOn && txOn));
  p_txbit_r9: assert property (@(posedge clk) disable iff (!rst_n) !txOn |-> !txBitOut);
  p_prog_pwr_r2: assert property (@(posedge clk) disable iff (!rst_n) !busEnN |-> (regPwrUp && trxPwrUp));
  p_prog_hold_r3: assert property (@(posedge clk) disable iff (!rst_n) (!busEnN && !shiftDone) |=> !busEnN);
  p_prog_end_r3: assert property (@(posedge clk) disable iff (!rst_n) (!busEnN && shiftDone) |=> (busEnN && busy));
  p_settle_rx_r4: assert property (@(posedge clk) disable iff (!rst_n) $rose(rxOn) |-> (sinceEn == PLL_W));
  p_rx_keep_r6: assert property (@(posedge clk) disable iff (!rst_n) (rxOn && !endSlot) |=> rxOn);
  p_openloop_r7: assert property (@(posedge clk) disable iff (!rst_n) txOn == !openLoopN);
  p_busy_slot_r12: assert property (@(posedge clk) disable iff (!rst_n) (rxOn || txOn) |-> !busy);
  p_busy_prog_r12: assert property (@(posedge clk) disable iff (!rst_n) !busEnN |-> busy);

endmodule

bind radio_slot_seq slot_seq_chk #(
  .PLL_CYC     (PLL_CYC),
  .COLD_TX_CYC (COLD_TX_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shiftDone (shiftDone),
  .endSlot   (endSlot),
  .regPwrUp  (regPwrUp),
  .trxPwrUp  (trxPwrUp),
  .busEnN    (busEnN),
  .rxOn      (rxOn),
  .txOn      (txOn),
  .openLoopN (openLoopN),
  .txBitOut  (txBitOut),
  .busy      (busy)
);

// File: tb/sim_radio_slot_seq.sv
module sim_radio_slot_seq;

  localparam int PWR  = 5;
  localparam int PLL  = 9;
  localparam int COLD = 12;
  localparam int PRE  = 6;
  localparam int BITC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slotReq = 1'b0, slotIsTx = 1'b0, sleepReq = 1'b0, endSlot = 1'b0;
  logic shiftDone = 1'b0, txBitIn = 1'b0;
  logic regPwrUp, trxPwrUp, busEnN, rxOn, txOn, openLoopN, txBitOut, txPayloadEn, busy;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  radio_slot_seq #(
    .PWR_CYC(PWR), .PLL_CYC(PLL), .COLD_TX_CYC(COLD), .PRE_BITS(PRE), .BIT_CYC(BITC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .slotReq(slotReq), .slotIsTx(slotIsTx),
    .sleepReq(sleepReq), .endSlot(endSlot), .shiftDone(shiftDone), .txBitIn(txBitIn),
    .regPwrUp(regPwrUp), .trxPwrUp(trxPwrUp), .busEnN(busEnN), .rxOn(rxOn),
    .txOn(txOn), .openLoopN(openLoopN), .txBitOut(txBitOut),
    .txPayloadEn(txPayloadEn), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic checkOff(input string req);
    chk({req, " regPwrUp"}, regPwrUp, 0);
    chk({req, " trxPwrUp"}, trxPwrUp, 0);
    chk({req, " rxOn"}, rxOn, 0);
    chk({req, " txOn"}, txOn, 0);
    chk({req, " busEnN"}, busEnN, 1);
    chk({req, " openLoopN"}, openLoopN, 1);
    chk({req, " txBitOut"}, txBitOut, 0);
    chk({req, " busy"}, busy, 0);
  endtask

  // request from power-down, measure the power-up wait (R2)
  task automatic coldRequest(input bit tx);
    int n;
    slotReq = 1'b1; slotIsTx = tx;
    tick();
    slotReq = 1'b0;
    chk("R2 power lines up", {30'd0, regPwrUp, trxPwrUp}, 3);
    chk("R12 busy in power-up", busy, 1);
    n = 0;
    while (busEnN && n < 100) begin tick(); n++; end
    chk("R2 power-up wait", n, PWR);
  endtask

  // external shift port model (R3)
  task automatic runProg();
    int n = 0;
    while (busEnN && n < 100) begin tick(); n++; end
    for (int i = 0; i < 3; i++) begin
      chk("R3 enable held low", busEnN, 0);
      chk("R12 busy while programming", busy, 1);
      tick();
    end
    shiftDone = 1'b1;
    tick();
    shiftDone = 1'b0;
    chk("R3 enable back high", busEnN, 1);
  endtask

  // settling count from busEnN rise to slot enable; optional held request at n==2
  task automatic measureSettle(input int exp, input bit tx, input bit inject, input string req);
    int n = 0;
    while (!(tx ? txOn : rxOn) && n < 100) begin
      if (!busy) chk({req, " busy during settle"}, busy, 1);
      if (inject && n == 2) begin
        slotReq = 1'b1; slotIsTx = 1'b0;
      end else begin
        slotReq = 1'b0;
      end
      tick();
      n++;
    end
    slotReq = 1'b0;
    chk(req, n, exp);
    chk("R9 exclusive enables", {30'd0, rxOn, txOn}, tx ? 1 : 2);
  endtask

  // compare every transmit cycle against the preamble/payload rule (R7, R8)
  task automatic checkTx(input int payBits);
    int len = (PRE + payBits) * BITC;
    for (int i = 0; i < len; i++) begin
      int k = i / BITC;
      int expBit;
      txBitIn = ((i * 7 + 3) % 5) < 2;
      #1;
      expBit = (k < PRE) ? ((k % 2) == 0) : txBitIn;
      chk("R8 tx bit", txBitOut, expBit);
      chk("R8 payload flag", txPayloadEn, (k >= PRE));
      chk("R7 open loop low", openLoopN, 0);
      chk("R12 busy low in slot", busy, 0);
      tick();
    end
  endtask

  task automatic finishSlot(input bit sleep);
    endSlot = 1'b1; sleepReq = sleep;
    tick();
    endSlot = 1'b0; sleepReq = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    checkOff("R1 reset");
    rst_n = 1'b1;
    tick();
    checkOff("R1 after reset");

    // cold receive slot
    coldRequest(1'b0);
    runProg();
    measureSettle(PLL, 1'b0, 1'b0, "R4 rx settle");
    for (int i = 0; i < 5; i++) begin
      chk("R6 rx held", rxOn, 1);
      chk("R6 tx low", txOn, 0);
      chk("R7 open loop high in rx", openLoopN, 1);
      chk("R9 no tx data in rx", txBitOut, 0);
      tick();
    end
    finishSlot(1'b0);
    chk("R10 stay powered", regPwrUp, 1);
    chk("R10 rx dropped", rxOn, 0);
    chk("R12 idle not busy", busy, 0);

    // warm transmit from idle
    slotReq = 1'b1; slotIsTx = 1'b1;
    tick();
    slotReq = 1'b0;
    chk("R10 no power-up wait", busEnN, 0);
    runProg();
    measureSettle(PLL, 1'b1, 1'b0, "R4 warm tx settle");
    checkTx(5);
    finishSlot(1'b1);
    checkOff("R10 sleep");

    // cold transmit with a receive request held during settling
    coldRequest(1'b1);
    runProg();
    measureSettle(COLD, 1'b1, 1'b1, "R5 cold tx settle");
    checkTx(2);
    finishSlot(1'b1);
    chk("R11 held request wins over sleep", busEnN, 0);
    chk("R11 power kept", regPwrUp, 1);
    chk("R11 tx dropped", txOn, 0);
    runProg();
    measureSettle(PLL, 1'b0, 1'b0, "R11 held direction rx");
    finishSlot(1'b1);
    checkOff("R10 sleep after held slot");

    // sweep of warm turnarounds in both directions
    coldRequest(1'b0);
    runProg();
    measureSettle(PLL, 1'b0, 1'b0, "R4 sweep first rx");
    for (int s = 0; s < 4; s++) begin
      bit nextTx = (s % 2) == 0;
      slotReq = 1'b1; slotIsTx = nextTx;
      tick();
      slotReq = 1'b0;
      finishSlot(1'b1);
      chk("R11 turnaround starts programming", busEnN, 0);
      runProg();
      measureSettle(PLL, nextTx, 1'b0, "R4 turnaround settle");
      if (nextTx) checkTx(1);
    end
    finishSlot(1'b1);
    checkOff("R10 final sleep");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule